// File: doc/BRIEF.md
# Power-Up Strap Capture and Output Release Sequencer

This block controls the pins of a clock generator that serve two purposes. While the supply ramps, two shared pads are inputs. They carry configuration straps, and the external pull-ups make a pad that nobody drives read as 1. An analog threshold detector outside this block sends a power-good indication. On the first cycle in which that indication is high, the block samples both pads once into strap registers. From the next cycle on, every managed pin is an output driven low. A settling counter on the reference clock then runs for a parameterised number of cycles, about 43 thousand cycles for 3 ms at 14.318 MHz. Only when the counter expires are the clock sources passed to the pins.

The two straps set how pins behave for as long as the block stays out of reset. The frequency strap picks whether a shared output carries the 24 MHz source or the 48 MHz source. The mode strap picks between two uses of a pair of further pins. In one mode they are extra PCI clock outputs. In the other they are active-low stop inputs, and the block forwards them to the clock-stopping logic. The block has no configuration path other than these two captured pads.

Top module: `strap_release_seq`

## Requirements
- R1: While rst_n is low, every output enable (fsel_pad_oe, mode_pad_oe, fs_oe, dual_oe) is 0, every data output is 0, and pci_stop_n and cpu_stop_n are 1.
- R2: After reset and before the first cycle with pwr_good high, every output enable stays 0, whatever the pad levels.
- R3: In the cycle after the first pwr_good-high cycle, fsel_pad, mode_pad and fs are driven (oe = 1) with the value 0.
- R4: The straps are the levels of fsel_pad_in and mode_pad_in in the first pwr_good-high cycle. Later pad levels and later pwr_good pulses do not change them, as the mapping in R6 to R8 shows.
- R5: The driven-low state lasts exactly HOLD_CYC cycles after the capture edge. During that time all data outputs are 0 and both stop outputs are 1.
- R6: After release, fs_out follows half_src when the captured frequency strap is 1 and usb_src when it is 0.
- R7: With the mode strap at 1, after release dual_oe = 2'b11, both dual_out bits follow pci_src, and pci_stop_n = cpu_stop_n = 1.
- R8: With the mode strap at 0, dual_oe stays 2'b00 for the whole powered period. After release, pci_stop_n follows dual_in[0] and cpu_stop_n follows dual_in[1].
- R9: After release, fsel_pad_out follows ref_src and mode_pad_out follows usb_src, with both enables at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock that runs the sequencer and the settling counter |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| pwr_good | input | 1 | Supply threshold indication; its first high cycle latches the straps |
| ref_src | input | 1 | Reference clock level that goes out on the frequency strap pad |
| usb_src | input | 1 | 48 MHz source level |
| half_src | input | 1 | 24 MHz source level |
| pci_src | input | 1 | PCI clock source level for the dual pins |
| fsel_pad_in | input | 1 | Level on the frequency strap pad |
| fsel_pad_oe | output | 1 | Drive enable of the frequency strap pad |
| fsel_pad_out | output | 1 | Value driven on the frequency strap pad |
| mode_pad_in | input | 1 | Level on the mode strap pad |
| mode_pad_oe | output | 1 | Drive enable of the mode strap pad |
| mode_pad_out | output | 1 | Value driven on the mode strap pad |
| fs_oe | output | 1 | Drive enable of the 24/48 MHz output |
| fs_out | output | 1 | 24/48 MHz output value |
| dual_in | input | 2 | Levels on the dual pins (bit 0 PCI stop, bit 1 CPU stop) |
| dual_oe | output | 2 | Drive enables of the dual pins |
| dual_out | output | 2 | Values driven on the dual pins |
| pci_stop_n | output | 1 | Active-low PCI stop request forwarded from dual_in[0] |
| cpu_stop_n | output | 1 | Active-low CPU stop request forwarded from dual_in[1] |

## Verification
If the phase register were wrong, pins would drive too early or too late, and every enable and data port would show it in the very next cycle. If the settling counter were off by even one, release would come one cycle early or late. The bench therefore checks every cycle of the hold window and the exact first release cycle. If a strap register captured the wrong level, or captured again later, the fs output or the dual pins would carry the wrong source on the first cycle after release. So the bench moves the pad levels and sends a second power-good pulse after capture.

// File: rtl/strap_seq_pkg.sv
package strap_seq_pkg;
  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_HOLD = 2'd1,
    PH_LIVE = 2'd2
  } phase_e;

  typedef struct packed {
    logic sel_half;  // 1: shared output carries 24 MHz
    logic pins_pci;  // 1: dual pins are PCI clock outputs
  } straps_t;
endpackage

// File: rtl/strap_capture.sv
module strap_capture
  import strap_seq_pkg::*;
(
  input  logic    clk_ref,
  input  logic    rst_n,
  input  logic    capture_en,
  input  logic    fsel_lvl,
  input  logic    mode_lvl,
  output straps_t straps
);
  straps_t straps_q;
  straps_t straps_d;

  always_comb begin
    straps_d = straps_q;
    if (capture_en) begin
      straps_d.sel_half = fsel_lvl;
      straps_d.pins_pci = mode_lvl;
    end
  end

  // reset to pull-up defaults
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      straps_q <= '{sel_half: 1'b1, pins_pci: 1'b1};
    end else if (capture_en) begin
      straps_q <= straps_d;
    end
  end

  assign straps = straps_q;
endmodule

// File: rtl/release_timer.sv
module release_timer
  import strap_seq_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 42955
) (
  input  logic   clk_ref,
  input  logic   rst_n,
  input  logic   pwr_good,
  output phase_e phase,
  output logic   capture_en
);
  localparam int unsigned CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (phase_q)
      PH_WAIT: begin
        if (pwr_good) begin
          phase_d = PH_HOLD;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      PH_HOLD: begin
        cnt_en = 1'b1;
        if (cnt_q == LAST) begin
          phase_d = PH_LIVE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        phase_d = PH_LIVE;
      end
    endcase
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_WAIT;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign phase      = phase_q;
  assign capture_en = (phase_q == PH_WAIT) && pwr_good;
endmodule

// File: rtl/pad_mux.sv
module pad_mux
  import strap_seq_pkg::*;
#(
  parameter int unsigned NUM_DUAL = 2
) (
  input  phase_e              phase,
  input  straps_t             straps,
  input  logic                ref_src,
  input  logic                usb_src,
  input  logic                half_src,
  input  logic                pci_src,
  input  logic [NUM_DUAL-1:0] dual_in,
  output logic                fsel_pad_oe,
  output logic                fsel_pad_out,
  output logic                mode_pad_oe,
  output logic                mode_pad_out,
  output logic                fs_oe,
  output logic                fs_out,
  output logic [NUM_DUAL-1:0] dual_oe,
  output logic [NUM_DUAL-1:0] dual_out,
  output logic [NUM_DUAL-1:0] stop_n
);
  logic driving;
  logic live;

  assign driving = (phase != PH_WAIT);
  assign live    = (phase == PH_LIVE);

  assign fsel_pad_oe  = driving;
  assign mode_pad_oe  = driving;
  assign fs_oe        = driving;
  assign fsel_pad_out = live & ref_src;
  assign mode_pad_out = live & usb_src;
  assign fs_out       = live & (straps.sel_half ? half_src : usb_src);

  for (genvar g = 0; g < NUM_DUAL; g++) begin : g_dual
    assign dual_oe[g]  = driving & straps.pins_pci;
    assign dual_out[g] = live & straps.pins_pci & pci_src;
    assign stop_n[g]   = ~live | straps.pins_pci | dual_in[g];
  end
endmodule

// File: rtl/strap_release_seq.sv
module strap_release_seq
  import strap_seq_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 42955
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic       ref_src,
  input  logic       usb_src,
  input  logic       half_src,
  input  logic       pci_src,
  input  logic       fsel_pad_in,
  output logic       fsel_pad_oe,
  output logic       fsel_pad_out,
  input  logic       mode_pad_in,
  output logic       mode_pad_oe,
  output logic       mode_pad_out,
  output logic       fs_oe,
  output logic       fs_out,
  input  logic [1:0] dual_in,
  output logic [1:0] dual_oe,
  output logic [1:0] dual_out,
  output logic       pci_stop_n,
  output logic       cpu_stop_n
);
  localparam int unsigned NUM_DUAL = 2;

  phase_e              phase;
  logic                capture_en;
  straps_t             straps;
  logic [NUM_DUAL-1:0] stop_n;

  release_timer #(.HOLD_CYC(HOLD_CYC)) timer_i (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .pwr_good   (pwr_good),
    .phase      (phase),
    .capture_en (capture_en)
  );

  strap_capture cap_i (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .capture_en (capture_en),
    .fsel_lvl   (fsel_pad_in),
    .mode_lvl   (mode_pad_in),
    .straps     (straps)
  );

  pad_mux #(.NUM_DUAL(NUM_DUAL)) mux_i (
    .phase        (phase),
    .straps       (straps),
    .ref_src      (ref_src),
    .usb_src      (usb_src),
    .half_src     (half_src),
    .pci_src      (pci_src),
    .dual_in      (dual_in),
    .fsel_pad_oe  (fsel_pad_oe),
    .fsel_pad_out (fsel_pad_out),
    .mode_pad_oe  (mode_pad_oe),
    .mode_pad_out (mode_pad_out),
    .fs_oe        (fs_oe),
    .fs_out       (fs_out),
    .dual_oe      (dual_oe),
    .dual_out     (dual_out),
    .stop_n       (stop_n)
  );

  assign pci_stop_n = stop_n[0];
  assign cpu_stop_n = stop_n[1];
endmodule

// File: rtl/strap_release_chk.sv
module strap_release_chk #(
  parameter int unsigned HOLD_CYC = 42955
) (
  input logic       clk_ref,
  input logic       rst_n,
  input logic       pwr_good,
  input logic       ref_src,
  input logic       usb_src,
  input logic       half_src,
  input logic       pci_src,
  input logic       fsel_pad_in,
  input logic       fsel_pad_oe,
  input logic       fsel_pad_out,
  input logic       mode_pad_in,
  input logic       mode_pad_oe,
  input logic       mode_pad_out,
  input logic       fs_oe,
  input logic       fs_out,
  input logic [1:0] dual_in,
  input logic [1:0] dual_oe,
  input logic [1:0] dual_out,
  input logic       pci_stop_n,
  input logic       cpu_stop_n
);
  logic        seen;
  logic        k_sel, k_mode;
  logic [31:0] hcnt;
  logic        released;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      seen   <= 1'b0;
      k_sel  <= 1'b1;
      k_mode <= 1'b1;
      hcnt   <= '0;
    end else begin
      if (!seen && pwr_good) begin
        seen   <= 1'b1;
        k_sel  <= fsel_pad_in;
        k_mode <= mode_pad_in;
      end
      if (seen && hcnt < HOLD_CYC) hcnt <= hcnt + 32'd1;
    end
  end

  assign released = seen && (hcnt == HOLD_CYC);

  assert_reset_quiet_R1: assert property (@(posedge clk_ref)
    !rst_n |-> (!fsel_pad_oe && !mode_pad_oe && !fs_oe && dual_oe == 2'b00 &&
                !fsel_pad_out && !mode_pad_out && !fs_out && dual_out == 2'b00 &&
                pci_stop_n && cpu_stop_n));

  assert_wait_tristate_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !seen |-> (!fsel_pad_oe && !mode_pad_oe && !fs_oe && dual_oe == 2'b00));

  assert_drive_low_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!seen && pwr_good) |=> (fsel_pad_oe && mode_pad_oe && fs_oe &&
                             !fsel_pad_out && !mode_pad_out && !fs_out));

  assert_hold_low_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (seen && hcnt < HOLD_CYC) |-> (!fsel_pad_out && !mode_pad_out && !fs_out &&
                                   dual_out == 2'b00 && pci_stop_n && cpu_stop_n));

  assert_fs_select_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    released |-> (fs_oe && fs_out == (k_sel ? half_src : usb_src)));

  assert_pci_pins_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (released && k_mode) |-> (dual_oe == 2'b11 && dual_out == {2{pci_src}} &&
                              pci_stop_n && cpu_stop_n));

  assert_stop_inputs_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (seen && !k_mode) |-> (dual_oe == 2'b00));

  assert_strap_pads_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
    released |-> (fsel_pad_out == ref_src && mode_pad_out == usb_src));
endmodule

bind strap_release_seq strap_release_chk #(.HOLD_CYC(HOLD_CYC)) chk_i (
  .clk_ref      (clk_ref),
  .rst_n        (rst_n),
  .pwr_good     (pwr_good),
  .ref_src      (ref_src),
  .usb_src      (usb_src),
  .half_src     (half_src),
  .pci_src      (pci_src),
  .fsel_pad_in  (fsel_pad_in),
  .fsel_pad_oe  (fsel_pad_oe),
  .fsel_pad_out (fsel_pad_out),
  .mode_pad_in  (mode_pad_in),
  .mode_pad_oe  (mode_pad_oe),
  .mode_pad_out (mode_pad_out),
  .fs_oe        (fs_oe),
  .fs_out       (fs_out),
  .dual_in      (dual_in),
  .dual_oe      (dual_oe),
  .dual_out     (dual_out),
  .pci_stop_n   (pci_stop_n),
  .cpu_stop_n   (cpu_stop_n)
);

// File: tb/strap_release_seq_tb.sv
module strap_release_seq_tb_top;
  localparam int unsigned HOLD = 40;

  logic       clk_ref = 1'b0;
  logic       rst_n, pwr_good;
  logic       ref_src, usb_src, half_src, pci_src;
  logic       fsel_pad_in, mode_pad_in;
  logic [1:0] dual_in;
  logic       fsel_pad_oe, fsel_pad_out, mode_pad_oe, mode_pad_out;
  logic       fs_oe, fs_out, pci_stop_n, cpu_stop_n;
  logic [1:0] dual_oe, dual_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk_ref = ~clk_ref;

  strap_release_seq #(.HOLD_CYC(HOLD)) dut_i (
    .clk_ref(clk_ref), .rst_n(rst_n), .pwr_good(pwr_good),
    .ref_src(ref_src), .usb_src(usb_src), .half_src(half_src), .pci_src(pci_src),
    .fsel_pad_in(fsel_pad_in), .fsel_pad_oe(fsel_pad_oe), .fsel_pad_out(fsel_pad_out),
    .mode_pad_in(mode_pad_in), .mode_pad_oe(mode_pad_oe), .mode_pad_out(mode_pad_out),
    .fs_oe(fs_oe), .fs_out(fs_out),
    .dual_in(dual_in), .dual_oe(dual_oe), .dual_out(dual_out),
    .pci_stop_n(pci_stop_n), .cpu_stop_n(cpu_stop_n)
  );

  // packed view of outputs: {fsel_oe,fsel_out,mode_oe,mode_out,fs_oe,fs_out,dual_oe,dual_out,pci_n,cpu_n}
  function automatic logic [11:0] observe();
    return {fsel_pad_oe, fsel_pad_out, mode_pad_oe, mode_pad_out, fs_oe, fs_out,
            dual_oe, dual_out, pci_stop_n, cpu_stop_n};
  endfunction

  function automatic logic [11:0] exp_reset();
    return {6'b000000, 2'b00, 2'b00, 2'b11};
  endfunction

  function automatic logic [11:0] exp_hold(input logic mode);
    return {6'b101010, mode ? 2'b11 : 2'b00, 2'b00, 2'b11};
  endfunction

  function automatic logic [11:0] exp_live(input logic sel, input logic mode,
                                           input logic r, input logic u, input logic h,
                                           input logic p, input logic [1:0] di);
    logic f;
    f = sel ? h : u;
    return {1'b1, r, 1'b1, u, 1'b1, f,
            mode ? 2'b11 : 2'b00, mode ? {p, p} : 2'b00,
            mode ? 1'b1 : di[0], mode ? 1'b1 : di[1]};
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive_random();
    ref_src  = 1'($urandom);
    usb_src  = 1'($urandom);
    half_src = 1'($urandom);
    pci_src  = 1'($urandom);
    dual_in  = 2'($urandom);
  endtask

  task automatic scenario(input logic sel, input logic mode, input int wait_cyc);
    logic [11:0] exp;
    @(negedge clk_ref);
    rst_n = 1'b0; pwr_good = 1'b0;
    fsel_pad_in = ~sel; mode_pad_in = ~mode;
    drive_random();
    repeat (2) @(posedge clk_ref);
    @(negedge clk_ref); #1;
    check("R1", observe(), exp_reset());
    rst_n = 1'b1;
    // before threshold: pads wiggle, nothing driven
    for (int i = 0; i < wait_cyc; i++) begin
      @(negedge clk_ref);
      fsel_pad_in = 1'($urandom); mode_pad_in = 1'($urandom);
      drive_random();
      #1;
      check("R2", {observe()[11], observe()[9], observe()[7], observe()[5:4], 7'b0},
            12'b0);
    end
    // threshold cycle: straps present on pads
    @(negedge clk_ref);
    fsel_pad_in = sel; mode_pad_in = mode; pwr_good = 1'b1;
    for (int k = 1; k <= int'(HOLD) + 12; k++) begin
      @(negedge clk_ref);
      pwr_good = (k == int'(HOLD) + 4);   // late pulse must be ignored (R4)
      fsel_pad_in = ~sel; mode_pad_in = ~mode;
      drive_random();
      #1;
      if (k <= int'(HOLD)) begin
        check(k == 1 ? "R3" : "R5", observe(), exp_hold(mode));
      end else begin
        exp = exp_live(sel, mode, ref_src, usb_src, half_src, pci_src, dual_in);
        if (k == int'(HOLD) + 1) check("R5", observe(), exp);
        else if (!mode) check("R8", observe(), exp);
        else check(sel ? "R6" : "R7", observe(), exp);
        check("R4", {11'b0, fs_out}, {11'b0, sel ? half_src : usb_src});
        check("R9", {10'b0, fsel_pad_out, mode_pad_out}, {10'b0, ref_src, usb_src});
      end
    end
    pwr_good = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1337));
    rst_n = 1'b0; pwr_good = 1'b0;
    fsel_pad_in = 1'b1; mode_pad_in = 1'b1;
    ref_src = 0; usb_src = 0; half_src = 0; pci_src = 0; dual_in = 2'b11;
    // directed corners: pwr_good right after reset release, and all strap combos
    scenario(1'b1, 1'b1, 0);
    scenario(1'b0, 1'b1, 3);
    scenario(1'b1, 1'b0, 5);
    scenario(1'b0, 1'b0, 1);
    for (int n = 0; n < 4; n++) begin
      scenario(1'($urandom), 1'($urandom), int'($urandom_range(0, 8)));
    end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_ref);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule